// File: doc/BRIEF.md
# In-Memory Bubble Sort Engine

This block sorts an array of 32-bit words in place in external memory. A host sets it up through a small register-mapped request/response port. It writes the array's byte address and its element count, then writes the control register to start. Completion is found by reading the control register. That read is held off until the sort is over and is then answered with the value 1.

The engine moves through the array one element per memory round trip. It keeps the larger of each pair in a holding register. Each smaller value goes back into the slot before the one just read. When a pass ends, the held value is written to the pass's last slot. The number of passes equals the element count. Memory traffic goes over a request channel and a response channel, each with a valid/ready handshake. No more than one request is in flight at any time.

Top module: `bsort_accel`

## Requirements
- R1: After reset, `hreq_ready_o` is high and `hrsp_valid_o`, `mreq_valid_o` and `mrsp_ready_o` are low.
- R2: A host write (`hreq_wr_i`=1) to index 1 sets the array base address, and one to index 2 sets the element count. A write to index 3 is accepted with no effect. Every write is answered one cycle after acceptance with `hrsp_wr_o`=1 and `hrsp_data_o`=0.
- R3: A write to index 0 with a count of 2 or more is acknowledged and starts a sort. The host port then accepts no request (`hreq_ready_o` low) until the sort has finished.
- R4: A host read (`hreq_wr_i`=0) of index 0 is accepted only while idle and is answered one cycle later with `hrsp_wr_o`=0 and data 1. A read of any other index returns data 0.
- R5: Element i is at byte address base + 4·i. The first memory request after a start is a read (`mreq_wr_o`=0) of the base address.
- R6: When the sort ends, the array is in ascending order as unsigned 32-bit values. The sort runs exactly count passes, and each pass makes count reads and count writes, so it issues 2·count² memory requests in total.
- R7: A start with a count of 0 or 1 is acknowledged, issues no memory request, and leaves the engine idle.
- R8: At most one memory request is outstanding at a time. A request whose `mreq_ready_i` is low is held with unchanged address, data and type.
- R9: A host response that is not accepted (`hrsp_ready_i` low) stays valid with unchanged type and data.
- R10: Every memory access falls on a word offset of the base address inside [base, base + 4·(count−1)]. Memory outside that range is left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hreq_valid_i | input | 1 | Host request valid |
| hreq_ready_o | output | 1 | Host request accepted |
| hreq_wr_i | input | 1 | Host request is a write |
| hreq_idx_i | input | RIDX_W | Register index |
| hreq_data_i | input | DATA_W | Host write data |
| hrsp_valid_o | output | 1 | Host response valid |
| hrsp_ready_i | input | 1 | Host takes response |
| hrsp_wr_o | output | 1 | Response answers a write |
| hrsp_data_o | output | DATA_W | Response data |
| mreq_valid_o | output | 1 | Memory request valid |
| mreq_ready_i | input | 1 | Memory takes request |
| mreq_wr_o | output | 1 | Memory request is a write |
| mreq_addr_o | output | DATA_W | Byte address |
| mreq_data_o | output | DATA_W | Write data |
| mrsp_valid_i | input | 1 | Memory response valid |
| mrsp_ready_o | output | 1 | Engine takes response |
| mrsp_data_i | input | DATA_W | Read data (ignored for writes) |

## Verification
A host response is due exactly one cycle after its request is accepted. The bench drives on falling edges and expects the response at the first falling edge after the acceptance edge, with no extra wait. The start handshake is followed one cycle later by a check that the host port has closed. The completion read, which the port holds off, is checked at the moment it is answered: all 2·count² memory transactions must already have been counted, and memory must already be sorted. The memory model logs each handshake at the falling edge before the clock edge that takes it. It then answers one cycle later, so request order, addresses and ranges can be checked one by one.

// File: rtl/bsort_pkg.sv
`timescale 1ns/1ps
package bsort_pkg;
  localparam int REG_CTRL = 0;
  localparam int REG_BASE = 1;
  localparam int REG_LEN  = 2;
  localparam int WORD_SHIFT = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FIRST0, ST_FIRST1, ST_BUB0, ST_BUB1, ST_LAST
  } sort_state_e;
endpackage

// File: rtl/bsort_cfg.sv
`timescale 1ns/1ps
module bsort_cfg import bsort_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int RIDX_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              hreq_valid_i,
  output logic              hreq_ready_o,
  input  logic              hreq_wr_i,
  input  logic [RIDX_W-1:0] hreq_idx_i,
  input  logic [DATA_W-1:0] hreq_data_i,
  output logic              hrsp_valid_o,
  input  logic              hrsp_ready_i,
  output logic              hrsp_wr_o,
  output logic [DATA_W-1:0] hrsp_data_o,
  output logic [DATA_W-1:0] base_o,
  output logic [DATA_W-1:0] len_o,
  output logic              start_o
);
  logic fire, is_ctrl;
  logic [DATA_W-1:0] base_q, len_q;

  assign hreq_ready_o = !busy_i && !hrsp_valid_o;
  assign fire         = hreq_valid_i && hreq_ready_o;
  assign is_ctrl      = hreq_idx_i == RIDX_W'(REG_CTRL);
  // short arrays are already sorted: ack only
  assign start_o      = fire && hreq_wr_i && is_ctrl && (len_q >= DATA_W'(2));
  assign base_o       = base_q;
  assign len_o        = len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q       <= '0;
      len_q        <= '0;
      hrsp_valid_o <= 1'b0;
      hrsp_wr_o    <= 1'b0;
      hrsp_data_o  <= '0;
    end else begin
      if (hrsp_valid_o && hrsp_ready_i) hrsp_valid_o <= 1'b0;
      if (fire) begin
        hrsp_valid_o <= 1'b1;
        hrsp_wr_o    <= hreq_wr_i;
        hrsp_data_o  <= (!hreq_wr_i && is_ctrl) ? DATA_W'(1) : '0;
        if (hreq_wr_i && hreq_idx_i == RIDX_W'(REG_BASE)) base_q <= hreq_data_i;
        if (hreq_wr_i && hreq_idx_i == RIDX_W'(REG_LEN))  len_q  <= hreq_data_i;
      end
    end
  end
endmodule

// File: rtl/bsort_agen.sv
`timescale 1ns/1ps
module bsort_agen import bsort_pkg::*; #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] base_i,
  input  logic [DATA_W-1:0] idx_i,
  input  logic              back_i,
  output logic [DATA_W-1:0] addr_o
);
  localparam logic [DATA_W-1:0] WORD_BYTES = DATA_W'(1) << WORD_SHIFT;
  assign addr_o = base_i + (idx_i << WORD_SHIFT) - (back_i ? WORD_BYTES : '0);
endmodule

// File: rtl/bsort_fsm.sv
`timescale 1ns/1ps
module bsort_fsm import bsort_pkg::*; #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] len_i,
  input  logic [DATA_W-1:0] addr_i,
  output logic [DATA_W-1:0] agen_idx_o,
  output logic              agen_back_o,
  output logic              busy_o,
  output logic              mreq_valid_o,
  input  logic              mreq_ready_i,
  output logic              mreq_wr_o,
  output logic [DATA_W-1:0] mreq_addr_o,
  output logic [DATA_W-1:0] mreq_data_o,
  input  logic              mrsp_valid_i,
  output logic              mrsp_ready_o,
  input  logic [DATA_W-1:0] mrsp_data_i
);
  sort_state_e state_q;
  logic [DATA_W-1:0] hold_q, inner_q, outer_q;
  logic [DATA_W-1:0] inner_inc, outer_inc, big_v, small_v;
  logic wait_rsp, rsp_fire, more_inner, more_outer, keep_hold;

  always_comb begin
    wait_rsp     = state_q inside {ST_FIRST1, ST_BUB0, ST_BUB1, ST_LAST};
    mrsp_ready_o = wait_rsp && !mreq_valid_o;
    rsp_fire     = mrsp_valid_i && mrsp_ready_o;
    inner_inc    = inner_q + DATA_W'(1);
    outer_inc    = outer_q + DATA_W'(1);
    more_inner   = inner_inc < len_i;
    more_outer   = outer_inc < len_i;
    keep_hold    = hold_q > mrsp_data_i;
    big_v        = keep_hold ? hold_q : mrsp_data_i;
    small_v      = keep_hold ? mrsp_data_i : hold_q;
    agen_idx_o   = '0;
    agen_back_o  = 1'b0;
    case (state_q)
      ST_FIRST1: agen_idx_o = inner_q;
      ST_BUB0: begin
        agen_idx_o  = inner_q;
        agen_back_o = 1'b1;
      end
      ST_BUB1: begin
        agen_idx_o  = inner_inc;
        agen_back_o = !more_inner;
      end
      default: agen_idx_o = '0;
    endcase
  end

  assign busy_o = state_q != ST_IDLE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      hold_q       <= '0;
      inner_q      <= '0;
      outer_q      <= '0;
      mreq_valid_o <= 1'b0;
      mreq_wr_o    <= 1'b0;
      mreq_addr_o  <= '0;
      mreq_data_o  <= '0;
    end else begin
      if (mreq_valid_o && mreq_ready_i) mreq_valid_o <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          outer_q <= '0;
          state_q <= ST_FIRST0;
        end
        ST_FIRST0: if (!mreq_valid_o) begin
          mreq_valid_o <= 1'b1;
          mreq_wr_o    <= 1'b0;
          mreq_addr_o  <= addr_i;
          inner_q      <= DATA_W'(1);
          state_q      <= ST_FIRST1;
        end
        ST_FIRST1: if (rsp_fire) begin
          hold_q       <= mrsp_data_i;
          mreq_valid_o <= 1'b1;
          mreq_wr_o    <= 1'b0;
          mreq_addr_o  <= addr_i;
          state_q      <= ST_BUB0;
        end
        ST_BUB0: if (rsp_fire) begin
          hold_q       <= big_v;
          mreq_valid_o <= 1'b1;
          mreq_wr_o    <= 1'b1;
          mreq_addr_o  <= addr_i;
          mreq_data_o  <= small_v;
          state_q      <= ST_BUB1;
        end
        ST_BUB1: if (rsp_fire) begin
          inner_q      <= inner_inc;
          mreq_valid_o <= 1'b1;
          mreq_addr_o  <= addr_i;
          if (more_inner) begin
            mreq_wr_o <= 1'b0;
            state_q   <= ST_BUB0;
          end else begin
            mreq_wr_o   <= 1'b1;
            mreq_data_o <= hold_q;
            state_q     <= ST_LAST;
          end
        end
        ST_LAST: if (rsp_fire) begin
          outer_q <= outer_inc;
          if (more_outer) begin
            mreq_valid_o <= 1'b1;
            mreq_wr_o    <= 1'b0;
            mreq_addr_o  <= addr_i;
            inner_q      <= DATA_W'(1);
            state_q      <= ST_FIRST1;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bsort_accel.sv
`timescale 1ns/1ps
module bsort_accel import bsort_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int RIDX_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hreq_valid_i,
  output logic              hreq_ready_o,
  input  logic              hreq_wr_i,
  input  logic [RIDX_W-1:0] hreq_idx_i,
  input  logic [DATA_W-1:0] hreq_data_i,
  output logic              hrsp_valid_o,
  input  logic              hrsp_ready_i,
  output logic              hrsp_wr_o,
  output logic [DATA_W-1:0] hrsp_data_o,
  output logic              mreq_valid_o,
  input  logic              mreq_ready_i,
  output logic              mreq_wr_o,
  output logic [DATA_W-1:0] mreq_addr_o,
  output logic [DATA_W-1:0] mreq_data_o,
  input  logic              mrsp_valid_i,
  output logic              mrsp_ready_o,
  input  logic [DATA_W-1:0] mrsp_data_i
);
  logic              busy, start, agen_back;
  logic [DATA_W-1:0] base, len, agen_idx, agen_addr;

  bsort_cfg #(.DATA_W(DATA_W), .RIDX_W(RIDX_W)) u_cfg (
    .clk_i, .rst_ni, .busy_i(busy),
    .hreq_valid_i, .hreq_ready_o, .hreq_wr_i, .hreq_idx_i, .hreq_data_i,
    .hrsp_valid_o, .hrsp_ready_i, .hrsp_wr_o, .hrsp_data_o,
    .base_o(base), .len_o(len), .start_o(start)
  );

  bsort_agen #(.DATA_W(DATA_W)) u_agen (
    .base_i(base), .idx_i(agen_idx), .back_i(agen_back), .addr_o(agen_addr)
  );

  bsort_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk_i, .rst_ni, .start_i(start), .len_i(len), .addr_i(agen_addr),
    .agen_idx_o(agen_idx), .agen_back_o(agen_back), .busy_o(busy),
    .mreq_valid_o, .mreq_ready_i, .mreq_wr_o, .mreq_addr_o, .mreq_data_o,
    .mrsp_valid_i, .mrsp_ready_o, .mrsp_data_i
  );
endmodule

module bsort_accel_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hreq_ready_o,
  input logic              hrsp_valid_o,
  input logic              hrsp_ready_i,
  input logic              hrsp_wr_o,
  input logic [DATA_W-1:0] hrsp_data_o,
  input logic              mreq_valid_o,
  input logic              mreq_ready_i,
  input logic              mreq_wr_o,
  input logic [DATA_W-1:0] mreq_addr_o,
  input logic [DATA_W-1:0] mreq_data_o,
  input logic              mrsp_valid_i,
  input logic              mrsp_ready_o
);
  logic [1:0] outst_q;
  logic req_fire, rsp_fire;
  assign req_fire = mreq_valid_o && mreq_ready_i;
  assign rsp_fire = mrsp_valid_i && mrsp_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) outst_q <= '0;
    else outst_q <= outst_q + {1'b0, req_fire} - {1'b0, rsp_fire};
  end

  // R8
  one_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outst_q <= 2'd1);
  // R8
  rsp_matches_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fire |-> outst_q == 2'd1);
  // R8
  mreq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mreq_valid_o && !mreq_ready_i) |=> (mreq_valid_o && $stable(mreq_addr_o)
      && $stable(mreq_data_o) && $stable(mreq_wr_o)));
  // R9
  hrsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hrsp_valid_o && !hrsp_ready_i) |=> (hrsp_valid_o && $stable(hrsp_wr_o)
      && $stable(hrsp_data_o)));
  // R3
  host_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hreq_ready_o |-> (outst_q == 2'd0 && !mreq_valid_o));
  // R4
  rd_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hrsp_valid_o && !hrsp_wr_o) |-> hrsp_data_o <= DATA_W'(1));
endmodule

bind bsort_accel bsort_accel_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i, .rst_ni, .hreq_ready_o, .hrsp_valid_o, .hrsp_ready_i, .hrsp_wr_o,
  .hrsp_data_o, .mreq_valid_o, .mreq_ready_i, .mreq_wr_o, .mreq_addr_o,
  .mreq_data_o, .mrsp_valid_i, .mrsp_ready_o
);

// File: tb/bsort_accel_test.sv
`timescale 1ns/1ps
module bsort_accel_test;
  localparam int DW = 32;
  localparam int MAXN = 12;

  int total = 0, bad = 0;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic hreq_valid_i = 0, hreq_ready_o, hreq_wr_i = 0;
  logic [1:0] hreq_idx_i = '0;
  logic [DW-1:0] hreq_data_i = '0;
  logic hrsp_valid_o, hrsp_ready_i = 1, hrsp_wr_o;
  logic [DW-1:0] hrsp_data_o;
  logic mreq_valid_o, mreq_ready_i, mreq_wr_o;
  logic [DW-1:0] mreq_addr_o, mreq_data_o;
  logic mrsp_valid_i, mrsp_ready_o;
  logic [DW-1:0] mrsp_data_i;

  bsort_accel uut (.*);

  logic [DW-1:0] mem [0:63];
  logic [DW-1:0] vin [MAXN];
  logic [DW-1:0] cur_base = '0, cur_len = '0;
  int req_cnt = 0, range_bad = 0;
  logic first_seen = 0;
  logic first_wr = 0;
  logic [DW-1:0] first_addr = '0;
  bit stall_en = 0;
  int stall_ctr = 0;
  bit qf = 0, rf = 0, qw = 0;
  logic [DW-1:0] qa = '0, qd = '0, off;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory model: one reply per accepted request, one cycle later
  initial begin
    mrsp_valid_i = 0; mrsp_data_i = '0; mreq_ready_i = 1;
    forever begin
      @(negedge clk_i);
      if (rf) mrsp_valid_i = 0;
      if (qf) begin
        req_cnt++;
        if (!first_seen) begin
          first_seen = 1; first_addr = qa; first_wr = qw;
        end
        off = qa - cur_base;
        if (off[1:0] != 2'b00 || (off >> 2) >= cur_len) range_bad++;
        if (qw) begin
          mem[qa[7:2]] = qd; mrsp_data_i = '0;
        end else mrsp_data_i = mem[qa[7:2]];
        mrsp_valid_i = 1;
      end
      stall_ctr++;
      mreq_ready_i = stall_en ? (stall_ctr % 3 != 0) : 1'b1;
      qf = mreq_valid_o && mreq_ready_i;
      qa = mreq_addr_o; qd = mreq_data_o; qw = mreq_wr_o;
      rf = mrsp_valid_i && mrsp_ready_o;
    end
  end

  task automatic host_op(input bit wr, input logic [1:0] idx, input logic [DW-1:0] d,
                         input logic [DW-1:0] exp_d, input string req, input int hold);
    @(negedge clk_i);
    if (hold > 0) hrsp_ready_i = 0;
    hreq_valid_i = 1; hreq_wr_i = wr; hreq_idx_i = idx; hreq_data_i = d;
    while (!hreq_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    hreq_valid_i = 0;
    chk(hrsp_valid_o, req, "response due one cycle after accept", DW'(hrsp_valid_o), 1);
    chk(hrsp_wr_o == wr, req, "response type", DW'(hrsp_wr_o), DW'(wr));
    chk(hrsp_data_o == exp_d, req, "response data", hrsp_data_o, exp_d);
    if (hold > 0) begin
      repeat (hold) @(negedge clk_i);
      chk(hrsp_valid_o && hrsp_data_o == exp_d && hrsp_wr_o == wr, "R9",
          "response held while not taken", hrsp_data_o, exp_d);
      hrsp_ready_i = 1;
      @(negedge clk_i);
      chk(!hrsp_valid_o, "R9", "response dropped after taken", DW'(hrsp_valid_o), 0);
    end
  endtask

  task automatic do_sort(input logic [DW-1:0] base, input int n, input string tag);
    logic [DW-1:0] e [MAXN];
    logic [DW-1:0] t;
    int bw;
    bw = int'(base >> 2);
    for (int i = 0; i < MAXN; i++) e[i] = vin[i];
    for (int p = 0; p < n; p++)
      for (int i = 0; i + 1 < n; i++)
        if (e[i] > e[i+1]) begin t = e[i]; e[i] = e[i+1]; e[i+1] = t; end
    for (int i = 0; i < n; i++) mem[bw+i] = vin[i];
    mem[bw+n] = 32'hDEAD_BEEF;
    if (bw > 0) mem[bw-1] = 32'hFEED_F00D;
    cur_base = base; cur_len = DW'(n);
    host_op(1, 2'd1, base, 0, "R2", 0);
    host_op(1, 2'd2, DW'(n), 0, "R2", 0);
    req_cnt = 0; range_bad = 0; first_seen = 0;
    host_op(1, 2'd0, 0, 0, "R3", 0);
    @(negedge clk_i);
    if (n >= 2) begin
      chk(!hreq_ready_o, "R3", {tag, " host port closed while sorting"}, DW'(hreq_ready_o), 0);
      host_op(0, 2'd0, 0, 1, "R4", 0);
      chk(req_cnt == 2*n*n, "R6", {tag, " request count at completion"}, DW'(req_cnt), DW'(2*n*n));
      chk(first_addr == base && !first_wr, "R5", {tag, " first request reads base"}, first_addr, base);
      for (int i = 0; i < n; i++)
        chk(mem[bw+i] == e[i], "R6", {tag, " sorted element"}, mem[bw+i], e[i]);
    end else begin
      chk(hreq_ready_o, "R7", {tag, " idle after short start"}, DW'(hreq_ready_o), 1);
      repeat (10) @(negedge clk_i);
      chk(req_cnt == 0, "R7", {tag, " no memory traffic"}, DW'(req_cnt), 0);
      host_op(0, 2'd0, 0, 1, "R7", 0);
      if (n == 1) chk(mem[bw] == vin[0], "R7", {tag, " element untouched"}, mem[bw], vin[0]);
    end
    chk(range_bad == 0, "R10", {tag, " accesses inside array"}, DW'(range_bad), 0);
    chk(mem[bw+n] == 32'hDEAD_BEEF, "R10", {tag, " word after array"}, mem[bw+n], 32'hDEAD_BEEF);
    if (bw > 0)
      chk(mem[bw-1] == 32'hFEED_F00D, "R10", {tag, " word before array"}, mem[bw-1], 32'hFEED_F00D);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk(hreq_ready_o, "R1", "host ready", DW'(hreq_ready_o), 1);
    chk(!hrsp_valid_o, "R1", "no response", DW'(hrsp_valid_o), 0);
    chk(!mreq_valid_o, "R1", "no memory request", DW'(mreq_valid_o), 0);
    chk(!mrsp_ready_o, "R1", "no memory response taken", DW'(mrsp_ready_o), 0);
  endtask

  task automatic t_config();
    host_op(1, 2'd1, 32'h40, 0, "R2", 3);
    host_op(1, 2'd2, 32'd5, 0, "R2", 0);
    host_op(0, 2'd0, 0, 1, "R4", 2);
  endtask

  task automatic t_basic();
    logic [DW-1:0] v [8] = '{32'd7, 32'd3, 32'd9, 32'd1, 32'd4, 32'd8, 32'd2, 32'd6};
    for (int i = 0; i < 8; i++) vin[i] = v[i];
    do_sort(32'h40, 8, "basic");
    for (int i = 0; i < 6; i++) vin[i] = DW'(60 - 10*i);
    do_sort(32'h20, 6, "reversed");
  endtask

  task automatic t_stall();
    logic [DW-1:0] v [10] = '{32'hFFFF_FFFF, 32'd1, 32'h8000_0000, 32'd5, 32'd5,
                              32'd0, 32'h7FFF_FFFF, 32'd1, 32'hFFFF_FFFE, 32'd3};
    for (int i = 0; i < 10; i++) vin[i] = v[i];
    stall_en = 1;
    do_sort(32'h44, 10, "stall_unsigned");
    stall_en = 0;
  endtask

  task automatic t_short();
    vin[0] = 32'h1234;
    do_sort(32'h80, 1, "count1");
    do_sort(32'h80, 0, "count0");
  endtask

  task automatic t_ignored();
    vin[0] = 32'd2; vin[1] = 32'd1; vin[2] = 32'd0;
    mem[24] = 2; mem[25] = 1; mem[26] = 0; mem[27] = 32'hDEAD_BEEF;
    host_op(1, 2'd1, 32'h60, 0, "R2", 0);
    host_op(1, 2'd2, 32'd3, 0, "R2", 0);
    host_op(1, 2'd3, 32'h100, 0, "R2", 0);
    host_op(0, 2'd1, 0, 0, "R4", 0);
    host_op(0, 2'd3, 0, 0, "R4", 0);
    cur_base = 32'h60; cur_len = 3;
    req_cnt = 0; range_bad = 0; first_seen = 0;
    host_op(1, 2'd0, 0, 0, "R3", 0);
    host_op(0, 2'd0, 0, 1, "R4", 0);
    chk(first_addr == 32'h60, "R2", "index 3 write left base unchanged", first_addr, 32'h60);
    chk(req_cnt == 18, "R2", "index 3 write left count unchanged", DW'(req_cnt), 18);
    chk(mem[24] == 0 && mem[25] == 1 && mem[26] == 2, "R6", "three element sort",
        mem[26], 2);
    chk(range_bad == 0 && mem[27] == 32'hDEAD_BEEF, "R10", "three element range",
        DW'(range_bad), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset();
    t_config();
    t_basic();
    t_stall();
    t_short();
    t_ignored();
    repeat (5) @(negedge clk_i);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule